// File: doc/BRIEF.md
# Parity-Banked Bilinear Texture Sampler

This block returns one bilinearly filtered RGBA texel on every clock. It takes an unsigned fixed-point texture coordinate (u, v). The texture lives in a small local memory that software fills through a write port before sampling starts. That memory is split into four banks by the low bit of the texel's column and the low bit of its row. Because of this split, the 2x2 neighbourhood under any sample point always falls into four different banks, and all four neighbours are read together in one cycle.

The integer part of the coordinate picks the top-left neighbour. The texture has a power-of-two width and height, and it wraps at both edges. The fractional bits weight a horizontal blend on the upper row and on the lower row, and then a vertical blend between the two rows. Each 8-bit colour channel is filtered on its own. Requests use a valid/ready handshake. Results come out in order on a valid/ready output, three cycles after acceptance. The pipeline freezes while a result waits for the consumer.

Top module: `texfetch_bilinear`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: A write stores `wr_texel` at texel column `wr_x`, row `wr_y`. The bank is chosen by {`wr_y[0]`,`wr_x[0]`}: 0 = even column and even row, 1 = odd column, 2 = odd row, 3 = both odd. A sample with zero fractional bits returns that texel unchanged.
- R3: The integer column x0 is `u[FRAC_BITS +: TEX_LOG2_W]` and the integer row y0 is `v[FRAC_BITS +: TEX_LOG2_H]`. The four neighbours used are (x0,y0), (x0+1,y0), (x0,y0+1) and (x0+1,y0+1).
- R4: Let fx and fy be the low `FRAC_BITS` of u and v, and let S = 2^FRAC_BITS. Per channel, h0 = t00*(S-fx) + t10*fx and h1 = t01*(S-fx) + t11*fx. The result is (h0*(S-fy) + h1*fy + S*S/2) / (S*S), truncated.
- R5: Column and row arithmetic wraps modulo the texture width and height. The neighbour after the last column or row is column or row 0, and coordinate bits above the texture size are ignored.
- R6: A request accepted in cycle c with `out_ready` high presents its result with `out_valid` in cycle c+3.
- R7: With `out_ready` held high, `req_ready` stays high and one result emerges per cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `req_ready` is 0, and `out_valid` and `out_texel` hold unchanged into the next cycle.
- R9: Results leave in request order, with none lost or duplicated. No more than three requests are in flight.
- R10: Channel k occupies bits [8k+7:8k] of a texel and is filtered independently of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sample request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_u | input | COORD_W | Horizontal coordinate, FRAC_BITS fractional bits |
| req_v | input | COORD_W | Vertical coordinate, FRAC_BITS fractional bits |
| wr_en | input | 1 | Texture write strobe |
| wr_x | input | TEX_LOG2_W | Texel column to write |
| wr_y | input | TEX_LOG2_H | Texel row to write |
| wr_texel | input | 32 | RGBA texel to write |
| out_valid | output | 1 | Filtered result present |
| out_ready | input | 1 | Consumer takes the result when high |
| out_texel | output | 32 | Filtered RGBA texel |

## Verification
The bench builds the block with an 8-column by 16-row texture, 4 fractional bits and 10-bit coordinates. The width and height differ, so a swapped axis or a swapped bank parity gives wrong values. The small texture lets random coordinates hit the right-edge and bottom-edge wraps often. The six integer bits also exercise wrapping of bits above the texture size. The whole texture fits in a short load, so every bank word is written with known data before sampling.

// File: rtl/texfetch_pkg.sv
package texfetch_pkg;
    localparam int CH_W    = 8;
    localparam int CH_N    = 4;
    localparam int TEXEL_W = CH_W * CH_N;

    // Bank numbering: bit 1 = row parity, bit 0 = column parity
    typedef enum logic [1:0] {
        BANK_EVEN_EVEN = 2'd0,
        BANK_ODDX      = 2'd1,
        BANK_ODDY      = 2'd2,
        BANK_ODD_ODD   = 2'd3
    } bank_id_e;

    function automatic bank_id_e bank_of(input logic col_lsb, input logic row_lsb);
        return bank_id_e'({row_lsb, col_lsb});
    endfunction
endpackage

// File: rtl/texfetch_bank.sv
module texfetch_bank #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/texfetch_lane.sv
module texfetch_lane #(
    parameter int FRAC = 4,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            en,
    input  logic [CW-1:0]   t00,
    input  logic [CW-1:0]   t10,
    input  logic [CW-1:0]   t01,
    input  logic [CW-1:0]   t11,
    input  logic [FRAC-1:0] fx,
    input  logic [FRAC-1:0] fy,
    output logic [CW-1:0]   pix
);
    localparam int HW  = CW + FRAC;
    localparam int VW  = CW + 2 * FRAC;
    localparam int ONE = 1 << FRAC;
    localparam int HALF = 1 << (2 * FRAC - 1);

    logic [FRAC:0]   wx1, wx0, wy1, wy0;
    logic [HW-1:0]   h0_n, h1_n, h0_q, h1_q;
    logic [FRAC-1:0] fy_q;
    logic [VW:0]     vsum;

    always_comb begin
        wx1  = {1'b0, fx};
        wx0  = (FRAC+1)'(ONE) - wx1;
        h0_n = HW'(t00) * HW'(wx0) + HW'(t10) * HW'(wx1);
        h1_n = HW'(t01) * HW'(wx0) + HW'(t11) * HW'(wx1);
    end

    always_ff @(posedge clk) begin
        if (en) begin
            h0_q <= h0_n;
            h1_q <= h1_n;
            fy_q <= fy;
        end
    end

    always_comb begin
        wy1  = {1'b0, fy_q};
        wy0  = (FRAC+1)'(ONE) - wy1;
        vsum = (VW+1)'(h0_q) * (VW+1)'(wy0) + (VW+1)'(h1_q) * (VW+1)'(wy1)
             + (VW+1)'(HALF);
    end

    always_ff @(posedge clk) begin
        if (en) pix <= CW'(vsum >> (2 * FRAC));
    end
endmodule

// File: rtl/texfetch_bilinear.sv
module texfetch_bilinear
    import texfetch_pkg::*;
#(
    parameter int TEX_LOG2_W = 5,
    parameter int TEX_LOG2_H = 5,
    parameter int FRAC_BITS  = 4,
    parameter int COORD_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [COORD_W-1:0]    req_u,
    input  logic [COORD_W-1:0]    req_v,
    input  logic                  wr_en,
    input  logic [TEX_LOG2_W-1:0] wr_x,
    input  logic [TEX_LOG2_H-1:0] wr_y,
    input  logic [TEXEL_W-1:0]    wr_texel,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [TEXEL_W-1:0]    out_texel
);
    localparam int BAW = (TEX_LOG2_W - 1) + (TEX_LOG2_H - 1);

    logic adv;
    logic [TEX_LOG2_W-1:0] x0, x1;
    logic [TEX_LOG2_H-1:0] y0, y1;
    logic [FRAC_BITS-1:0]  fx, fy;
    logic unused_coord_hi;

    assign adv       = !out_valid || out_ready;
    assign req_ready = adv;

    assign x0 = req_u[FRAC_BITS +: TEX_LOG2_W];
    assign y0 = req_v[FRAC_BITS +: TEX_LOG2_H];
    assign x1 = x0 + 1'b1;
    assign y1 = y0 + 1'b1;
    assign fx = req_u[FRAC_BITS-1:0];
    assign fy = req_v[FRAC_BITS-1:0];
    assign unused_coord_hi = ^{req_u[COORD_W-1:FRAC_BITS+TEX_LOG2_W],
                               req_v[COORD_W-1:FRAC_BITS+TEX_LOG2_H]};

    logic [TEXEL_W-1:0] bank_q [4];

    for (genvar b = 0; b < 4; b++) begin : g_bank
        localparam logic BX = 1'(b % 2);
        localparam logic BY = 1'(b / 2);
        logic [TEX_LOG2_W-1:0] xs;
        logic [TEX_LOG2_H-1:0] ys;
        logic [BAW-1:0]        raddr, waddr;
        logic                  we;

        assign xs    = (x0[0] == BX) ? x0 : x1;
        assign ys    = (y0[0] == BY) ? y0 : y1;
        assign raddr = {ys[TEX_LOG2_H-1:1], xs[TEX_LOG2_W-1:1]};
        assign waddr = {wr_y[TEX_LOG2_H-1:1], wr_x[TEX_LOG2_W-1:1]};
        assign we    = wr_en && (bank_of(wr_x[0], wr_y[0]) == bank_id_e'(b));

        texfetch_bank #(.AW(BAW), .DW(TEXEL_W)) u_bank (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wr_texel),
            .re    (adv),
            .raddr (raddr),
            .rdata (bank_q[b])
        );
    end

    // Stage 1: bank read data plus the sample's parity and fraction
    logic                 s1_valid, s1_px, s1_py;
    logic [FRAC_BITS-1:0] s1_fx, s1_fy;
    logic                 s2_valid;

    always_ff @(posedge clk) begin
        if (adv) begin
            s1_px <= x0[0];
            s1_py <= y0[0];
            s1_fx <= fx;
            s1_fy <= fy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s2_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            s1_valid  <= req_valid;
            s2_valid  <= s1_valid;
            out_valid <= s2_valid;
        end
    end

    // Put the bank words back into neighbour order
    logic [TEXEL_W-1:0] t00, t10, t01, t11;

    always_comb begin
        t00 = bank_q[int'(bank_of( s1_px,  s1_py))];
        t10 = bank_q[int'(bank_of(!s1_px,  s1_py))];
        t01 = bank_q[int'(bank_of( s1_px, !s1_py))];
        t11 = bank_q[int'(bank_of(!s1_px, !s1_py))];
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_lane
        texfetch_lane #(.FRAC(FRAC_BITS), .CW(CH_W)) u_lane (
            .clk (clk),
            .en  (adv),
            .t00 (t00[c*CH_W +: CH_W]),
            .t10 (t10[c*CH_W +: CH_W]),
            .t01 (t01[c*CH_W +: CH_W]),
            .t11 (t11[c*CH_W +: CH_W]),
            .fx  (s1_fx),
            .fy  (s1_fy),
            .pix (out_texel[c*CH_W +: CH_W])
        );
    end
endmodule

// File: rtl/texfetch_chk.sv
module texfetch_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [TW-1:0] out_texel
);
    logic [2:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight <= '0;
        else inflight <= inflight + 3'(req_valid && req_ready)
                                  - 3'(out_valid && out_ready);
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_texel));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 3'd3);

    // R9
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight == 3'd0 |-> !out_valid);
endmodule

bind texfetch_bilinear texfetch_chk #(.TW(texfetch_pkg::TEXEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_texel (out_texel)
);

// File: tb/tb_texfetch_bilinear.sv
module tb_texfetch_bilinear;
    localparam int LW = 3;
    localparam int LH = 4;
    localparam int FB = 4;
    localparam int CW = 10;
    localparam int NX = 1 << LW;
    localparam int NY = 1 << LH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_u = '0, req_v = '0;
    logic          wr_en = 1'b0;
    logic [LW-1:0] wr_x = '0;
    logic [LH-1:0] wr_y = '0;
    logic [31:0]   wr_texel = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [31:0]   out_texel;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [NX][NY];
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    texfetch_bilinear #(.TEX_LOG2_W(LW), .TEX_LOG2_H(LH), .FRAC_BITS(FB), .COORD_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_u(req_u), .req_v(req_v), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
        .wr_texel(wr_texel), .out_valid(out_valid), .out_ready(out_ready),
        .out_texel(out_texel)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Reference filter taken from R3, R4, R5
    function automatic logic [31:0] ref_px(input logic [CW-1:0] u, input logic [CW-1:0] v);
        int x0, x1, y0, y1, fx, fy, h0, h1, s;
        logic [31:0] r;
        x0 = (int'(u) >> FB) % NX;  x1 = (x0 + 1) % NX;
        y0 = (int'(v) >> FB) % NY;  y1 = (y0 + 1) % NY;
        fx = int'(u) % (1 << FB);   fy = int'(v) % (1 << FB);
        for (int c = 0; c < 4; c++) begin
            h0 = int'(model[x0][y0][c*8 +: 8]) * ((1 << FB) - fx) + int'(model[x1][y0][c*8 +: 8]) * fx;
            h1 = int'(model[x0][y1][c*8 +: 8]) * ((1 << FB) - fx) + int'(model[x1][y1][c*8 +: 8]) * fx;
            s  = h0 * ((1 << FB) - fy) + h1 * fy + (1 << (2*FB - 1));
            r[c*8 +: 8] = 8'(s >> (2*FB));
        end
        return r;
    endfunction

    task automatic write_texel(input int x, input int y, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_x = LW'(x); wr_y = LH'(y); wr_texel = d;
        model[x][y] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Single request, result timed and compared (R6 plus the given tag)
    task automatic one_sample(input logic [CW-1:0] u, input logic [CW-1:0] v,
                              input logic [31:0] exp, input string tag);
        int n;
        @(negedge clk);
        out_ready = 1'b1; req_valid = 1'b1; req_u = u; req_v = v;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!out_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R6 latency", 32'(n), 32'd3);
        chk(out_texel == exp, tag, out_texel, exp);
    endtask

    // Random traffic with a scoreboard; p_req / p_rdy in percent
    task automatic run_phase(input int n, input int p_req, input int p_rdy, input bit stream);
        bit stalled = 1'b0;
        logic [31:0] held = '0;
        int outs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (stalled) begin
                chk(out_valid == 1'b1, "R8 valid held", 32'(out_valid), 32'd1);
                chk(out_texel == held, "R8 data held", out_texel, held);
            end
            req_valid = ($urandom_range(99) < p_req);
            req_u     = CW'($urandom);
            req_v     = CW'($urandom);
            out_ready = ($urandom_range(99) < p_rdy);
            #1;
            if (stream) chk(req_ready == 1'b1, "R7 ready", 32'(req_ready), 32'd1);
            if (out_valid && !out_ready)
                chk(req_ready == 1'b0, "R8 ready low", 32'(req_ready), 32'd0);
            stalled = out_valid && !out_ready;
            held    = out_texel;
            if (out_valid && out_ready) begin
                outs++;
                if (exp_q.size() == 0) chk(1'b0, "R9 extra result", out_texel, 32'hx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(out_texel == e, "R4 R9 filtered", out_texel, e);
                end
            end
            if (req_valid && req_ready) exp_q.push_back(ref_px(req_u, req_v));
        end
        if (stream) chk(outs == n - 3, "R7 one per cycle", 32'(outs), 32'(n - 3));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);

        for (int x = 0; x < NX; x++)
            for (int y = 0; y < NY; y++)
                write_texel(x, y, $urandom);

        // R2: every bank parity, integer coordinates return the stored texel
        one_sample(CW'(2 << FB), CW'(4 << FB), model[2][4], "R2 bank0");
        one_sample(CW'(3 << FB), CW'(4 << FB), model[3][4], "R2 bank1");
        one_sample(CW'(2 << FB), CW'(5 << FB), model[2][5], "R2 bank2");
        one_sample(CW'(3 << FB), CW'(5 << FB), model[3][5], "R2 bank3");
        // R3/R4 fractional cases
        one_sample(CW'((1 << FB) | 15), CW'((1 << FB) | 15), ref_px(CW'((1 << FB) | 15), CW'((1 << FB) | 15)), "R3 R4 max frac");
        one_sample(CW'((6 << FB) | 8), CW'(9 << FB), ref_px(CW'((6 << FB) | 8), CW'(9 << FB)), "R4 half x");
        // R5: wrap on both edges, and high coordinate bits ignored
        one_sample(CW'(((NX-1) << FB) | 8), CW'(((NY-1) << FB) | 8),
                   ref_px(CW'(((NX-1) << FB) | 8), CW'(((NY-1) << FB) | 8)), "R5 corner wrap");
        one_sample(CW'((NX + 3) << FB), CW'((NY + 5) << FB), model[3][5], "R5 high bits");
        // R10: each channel in its own neighbour, midpoint sample
        write_texel(4, 6, 32'h000000FF);
        write_texel(5, 6, 32'h0000FF00);
        write_texel(4, 7, 32'h00FF0000);
        write_texel(5, 7, 32'hFF000000);
        one_sample(CW'((4 << FB) | 8), CW'((6 << FB) | 8), 32'h40404040, "R10 channels");

        // R7 streaming, then random handshakes with stalls (R8, R9)
        exp_q.delete();
        run_phase(40, 100, 100, 1'b1);
        exp_q.delete();
        @(negedge clk);
        out_ready = 1'b1; req_valid = 1'b0;
        repeat (5) @(negedge clk);
        run_phase(3000, 70, 60, 1'b0);
        run_phase(20, 0, 100, 1'b0);
        chk(exp_q.size() == 0, "R9 drained", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule